// File: doc/BRIEF.md
# Segmented LRU Victim Selector

This block keeps the replacement state of one 16-way cache set and names the way that should be evicted next. Each way carries a 4-bit recency rank and one reference bit. The ranks together form a true LRU stack, where rank 0 is the most recent way and rank 15 is the least recent way. The reference bit sorts the ways into two groups: lines that have been hit since they were filled, and lines that have not.

The victim is the least recent way among those with a clear reference bit. When every reference bit is set, the victim is the least recent way of the whole set. Two optional refinements can be enabled. The first is random promotion: a fill may set the new line's reference bit, based on an externally supplied random value. The second is aging: every fill clears the reference bit of the way that is least recent at that moment.

The surrounding cache controller reads `victim_way` to choose the way to refill. It then reports the refill on the fill strobe, and reports lookups that hit on the hit strobe. Tags, data and the random generator are outside this block.

Top module: `slru_victim_sel`

## Requirements
- R1: After reset, every way's rank equals its index and every reference bit is clear. `victim_way` is therefore 15.
- R2: A hit or a fill moves the touched way to rank 0. Every way whose rank was below the touched way's old rank moves up by one. The ranks always stay a permutation of 0 to 15.
- R3: A hit (with no fill in the same cycle) sets the reference bit of `hit_way`.
- R4: If at least one reference bit is clear, `victim_way` is the way with the largest rank among the ways whose reference bit is clear.
- R5: If all 16 reference bits are set, `victim_way` is the way with rank 15.
- R6: A fill without promotion leaves the filled way's reference bit clear.
- R7: Let N = `promo_exp`. If N is nonzero and bits N-1..0 of `rand_val` are all zero, a fill sets the filled way's reference bit. If N = 0, a fill never sets it.
- R8: When `aging_en` is 1, a fill clears the reference bit of the way that held rank 15 just before the fill. When `aging_en` is 0, a fill touches no other way's reference bit.
- R9: If `fill_vld` and `hit_vld` are both high in the same cycle, only the fill is applied and the hit is ignored.
- R10: `victim_way` is a combinational function of the stored state. An update caused by a strobe is reflected from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | A lookup hit this set |
| hit_way | input | 4 | Way that hit |
| fill_vld | input | 1 | A line is being filled into this set |
| fill_way | input | 4 | Way being filled |
| rand_val | input | 32 | Random value for promotion |
| promo_exp | input | 4 | Promotion probability exponent N (probability 1/2^N, where 0 means off) |
| aging_en | input | 1 | Enable aging on fill |
| victim_way | output | 4 | Way selected for eviction |

## Verification
The assertions assume that the strobes and way indices are never unknown. They also assume that `promo_exp` stays below the width of `rand_val`, so that the promotion mask is well defined. The stimulus drives every input to a known value in every cycle and limits `promo_exp` to 0 through 8. Random phases also exercise simultaneous hit and fill strobes, and fills that target a way other than the current victim, so that aging acts on a way other than the one being filled.

// File: rtl/slru_pkg.sv
package slru_pkg;

    // Action applied to the set in one cycle; a fill outranks a hit.
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_HIT  = 2'd1,
        ACT_FILL = 2'd2
    } slru_act_e;

endpackage

// File: rtl/slru_rank_update.sv
// Moves one way to rank 0 and shifts the younger ways down by one.
module slru_rank_update #(
    parameter int WAYS   = 16,
    parameter int RANK_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][RANK_W-1:0] rank_q,
    input  logic                        touch_en,
    input  logic [RANK_W-1:0]           touch_way,
    output logic [WAYS-1:0][RANK_W-1:0] rank_d
);

    logic [RANK_W-1:0] old_rank;

    always_comb begin
        old_rank = rank_q[touch_way];
        rank_d   = rank_q;
        if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (RANK_W'(w) == touch_way) begin
                    rank_d[w] = '0;
                end else if (rank_q[w] < old_rank) begin
                    rank_d[w] = rank_q[w] + RANK_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/slru_victim_pick.sv
// Oldest non-referenced way, falling back to the global LRU way.
module slru_victim_pick #(
    parameter int WAYS   = 16,
    parameter int RANK_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][RANK_W-1:0] rank_q,
    input  logic [WAYS-1:0]             refd_q,
    output logic [RANK_W-1:0]           victim,
    output logic [RANK_W-1:0]           lru_way
);

    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(WAYS - 1);

    logic              found;
    logic [RANK_W-1:0] best_way;
    logic [RANK_W-1:0] best_rank;

    always_comb begin
        found     = 1'b0;
        best_way  = '0;
        best_rank = '0;
        lru_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank_q[w] == OLDEST) begin
                lru_way = RANK_W'(w);
            end
            if (!refd_q[w] && (!found || rank_q[w] > best_rank)) begin
                found     = 1'b1;
                best_way  = RANK_W'(w);
                best_rank = rank_q[w];
            end
        end
        victim = found ? best_way : lru_way;
    end

endmodule

// File: rtl/slru_promo_gate.sv
// Promotion fires with probability 1/2^N: low N random bits all zero.
module slru_promo_gate #(
    parameter int RAND_W = 32,
    parameter int EXP_W  = 4
) (
    input  logic [RAND_W-1:0] rand_val,
    input  logic [EXP_W-1:0]  promo_exp,
    output logic              promote
);

    logic [RAND_W-1:0] mask;

    always_comb begin
        mask    = (RAND_W'(1) << promo_exp) - RAND_W'(1);
        promote = (promo_exp != '0) && ((rand_val & mask) == '0);
    end

endmodule

// File: rtl/slru_victim_sel.sv
module slru_victim_sel
    import slru_pkg::*;
#(
    parameter int WAYS   = 16,
    parameter int RAND_W = 32,
    parameter int EXP_W  = 4,
    localparam int RANK_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_vld,
    input  logic [RANK_W-1:0] hit_way,
    input  logic              fill_vld,
    input  logic [RANK_W-1:0] fill_way,
    input  logic [RAND_W-1:0] rand_val,
    input  logic [EXP_W-1:0]  promo_exp,
    input  logic              aging_en,
    output logic [RANK_W-1:0] victim_way
);

    typedef struct packed {
        logic [WAYS-1:0][RANK_W-1:0] rank;
        logic [WAYS-1:0]             refd;
    } set_state_t;

    set_state_t                  st_d, st_q;
    slru_act_e                   act;
    logic                        touch_en;
    logic [RANK_W-1:0]           touch_way;
    logic [WAYS-1:0][RANK_W-1:0] rank_nxt;
    logic [RANK_W-1:0]           lru_way;
    logic                        promote;

    // Decode the cycle's action; fill wins over hit.
    always_comb begin
        if (fill_vld)      act = ACT_FILL;
        else if (hit_vld)  act = ACT_HIT;
        else               act = ACT_IDLE;
        touch_en  = (act != ACT_IDLE);
        touch_way = (act == ACT_FILL) ? fill_way : hit_way;
    end

    slru_rank_update #(.WAYS(WAYS), .RANK_W(RANK_W)) rank_upd_i (
        .rank_q    (st_q.rank),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .rank_d    (rank_nxt)
    );

    slru_victim_pick #(.WAYS(WAYS), .RANK_W(RANK_W)) pick_i (
        .rank_q  (st_q.rank),
        .refd_q  (st_q.refd),
        .victim  (victim_way),
        .lru_way (lru_way)
    );

    slru_promo_gate #(.RAND_W(RAND_W), .EXP_W(EXP_W)) promo_i (
        .rand_val  (rand_val),
        .promo_exp (promo_exp),
        .promote   (promote)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rank = rank_nxt;
        case (act)
            ACT_HIT: begin
                st_d.refd[hit_way] = 1'b1;
            end
            ACT_FILL: begin
                if (aging_en) st_d.refd[lru_way] = 1'b0;
                st_d.refd[fill_way] = promote;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                st_q.rank[w] <= RANK_W'(w);
            end
            st_q.refd <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic [WAYS-1:0] rank_occ;
    always_comb begin
        rank_occ = '0;
        for (int w = 0; w < WAYS; w++) begin
            rank_occ[st_q.rank[w]] = 1'b1;
        end
    end

    assert_rank_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&rank_occ));

    assert_hit_mru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vld && !fill_vld) |=>
            (st_q.rank[$past(hit_way)] == '0) && st_q.refd[$past(hit_way)]);

    assert_fill_mru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> (st_q.rank[$past(fill_way)] == '0));

    assert_victim_unref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(&st_q.refd) |-> !st_q.refd[victim_way]);

    assert_victim_lru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.refd) |-> (st_q.rank[victim_way] == RANK_W'(WAYS - 1)));

    assert_fill_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && promo_exp == '0) |=> !st_q.refd[$past(fill_way)]);

    assert_fill_promo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && promote) |=> st_q.refd[$past(fill_way)]);

    assert_aging_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && aging_en && fill_way != lru_way) |=> !st_q.refd[$past(lru_way)]);

endmodule

// File: tb/slru_victim_sel_tb.sv
module slru_victim_sel_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hit_vld, fill_vld, aging_en;
    logic [3:0]  hit_way, fill_way, promo_exp;
    logic [31:0] rand_val;
    logic [3:0]  victim_way;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model: queue ordered MRU first, reference bits per way.
    int lru_q[$];
    bit refm[16];

    always #(CLK_PERIOD/2) clk = ~clk;

    slru_victim_sel dut_i (
        .clk(clk), .rst_n(rst_n),
        .hit_vld(hit_vld), .hit_way(hit_way),
        .fill_vld(fill_vld), .fill_way(fill_way),
        .rand_val(rand_val), .promo_exp(promo_exp),
        .aging_en(aging_en), .victim_way(victim_way)
    );

    task automatic model_reset();
        lru_q.delete();
        for (int w = 0; w < 16; w++) begin
            lru_q.push_back(w);
            refm[w] = 1'b0;
        end
    endtask

    function automatic int model_victim();
        for (int i = lru_q.size() - 1; i >= 0; i--) begin
            if (!refm[lru_q[i]]) return lru_q[i];
        end
        return lru_q[lru_q.size() - 1];
    endfunction

    task automatic model_touch(int w);
        for (int i = 0; i < lru_q.size(); i++) begin
            if (lru_q[i] == w) begin
                lru_q.delete(i);
                break;
            end
        end
        lru_q.push_front(w);
    endtask

    task automatic model_apply(bit hv, int hw, bit fv, int fw, int unsigned rv, int pe, bit ae);
        if (fv) begin
            bit prom;
            if (ae) refm[lru_q[15]] = 1'b0;
            prom = (pe != 0) && ((rv % (1 << pe)) == 0);
            refm[fw] = prom;
            model_touch(fw);
        end else if (hv) begin
            refm[hw] = 1'b1;
            model_touch(hw);
        end
    endtask

    task automatic check(string tag, int expv);
        n_vec++;
        if (int'(victim_way) !== expv) begin
            n_fail++;
            $display("FAIL %s: victim_way actual %0d expected %0d at %0t", tag, victim_way, expv, $time);
        end
    endtask

    // Drive one cycle from a negedge; compare at the next negedge.
    task automatic step(string tag, bit hv, int hw, bit fv, int fw, int unsigned rv, int pe, bit ae);
        hit_vld   = hv;  hit_way  = 4'(hw);
        fill_vld  = fv;  fill_way = 4'(fw);
        rand_val  = rv;  promo_exp = 4'(pe);
        aging_en  = ae;
        model_apply(hv, hw, fv, fw, rv, pe, ae);
        @(negedge clk);
        check(tag, model_victim());
    endtask

    initial begin
        rst_n = 1'b0;
        hit_vld = 0; fill_vld = 0; aging_en = 0;
        hit_way = 0; fill_way = 0; promo_exp = 0; rand_val = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset victim", 15);

        // R10: state visible after the edge; idle leaves victim unchanged
        step("R10 idle", 0, 0, 0, 0, 0, 0, 0);
        // R3/R4: hit way 15 -> next unreferenced oldest is way 14
        step("R3 hit sets ref", 1, 15, 0, 0, 0, 0, 0);
        check("R4 oldest unref", 14);
        // R6: plain fill of way 5, victim stays 14
        step("R6 fill plain", 0, 0, 1, 5, 0, 0, 0);
        // R2: hit way 14 moves it to MRU; victim becomes 13
        step("R2 touch order", 1, 14, 0, 0, 0, 0, 0);
        check("R2 victim after touch", 13);
        // R5: reference every way, oldest-first so way 0 ends global LRU
        model_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int w = 0; w < 16; w++) step("R3 hit all", 1, w, 0, 0, 0, 0, 0);
        check("R5 all referenced", 0);
        // R8: aging fill of way 7 clears way 0's ref; way 0 becomes victim
        step("R8 aging fill", 0, 0, 1, 7, 1, 0, 1);
        check("R8 aged lru victim", 0);
        // R7: promotion with N=3, rand low bits zero -> filled way referenced
        step("R7 promo fires", 0, 0, 1, 0, 32'h8, 3, 0);
        step("R7 promo misses", 0, 0, 1, 1, 32'h9, 3, 0);
        step("R7 N zero off", 0, 0, 1, 2, 32'h0, 0, 0);
        // R9: fill and hit together, hit ignored
        step("R9 fill wins", 1, 3, 1, 4, 1, 0, 0);
        step("R9 fill wins same way", 1, 6, 1, 6, 1, 0, 0);

        // Mixed random traffic compared every cycle against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom;
            bit hv = (r[2:0] < 3);
            bit fv = (r[5:3] < 2);
            int pe = int'(r[9:6]) % 9;
            bit ae = r[10];
            step("R4 random mix", hv, int'(r[14:11]), fv, int'(r[18:15]),
                 $urandom & 32'h0000_00ff, pe, ae);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule